// File: doc/BRIEF.md
# Mode Request Rejection Monitor

This block screens every software request to move the device into a new power or operating mode. When a request strobe arrives with a target mode code, five independent rules are evaluated in the same cycle against the current mode, the transition-busy flag, the mode-enable vector and the safe-event-pending flag. Each rule that fires sets its own sticky flag in a 32-bit status register. A request is accepted, and may start a transition, only when no rule fires.

Software reads the status register and a 5-bit enable mask over a small register bus. It clears a flag by writing one to its bit. Only supervisor writes change either register. The interrupt request is the OR of the flags whose mask bits are set.

Top module: `mode_req_monitor`

## Requirements
- R1: Reads with `reg_sel`=0 return the status register and reads with `reg_sel`=1 return the mask. Only bits 4:0 carry data and bits 31:5 read as zero. `reg_rdata` is zero when `reg_rd` is low.
- R2: A request made while `xfer_busy` is high sets status bit 4 on the next clock edge.
- R3: A request whose (current, target) pair is cleared in the permitted-transition table `ALLOW` (bit index current*16+target) sets bit 3. In the default table, target 0 is reachable only from mode 2, and target 7 only from mode 1.
- R4: A request for an implemented target whose bit in `mode_en` is clear sets bit 2.
- R5: A request for a code whose bit in `IMPL_MAP` is clear sets bit 1 and never sets bit 2. The default map implements codes 0-5 and 7.
- R6: A request made while the current mode is safe (code 2) and `safe_evt` is high sets bit 0, unless the target is reset (code 0) or safe (code 2).
- R7: All flags reset to 0. A supervisor write with `reg_sel`=0 clears each flag whose `reg_wdata` bit is 1. Zero bits leave their flags unchanged.
- R8: A write with `reg_sup` low changes neither the status register nor the mask.
- R9: When a rule sets a flag in the same cycle that software writes 1 to it, the flag ends up set.
- R10: A supervisor write with `reg_sel`=1 loads the mask from `reg_wdata[4:0]`, and the mask resets to 0. `irq` is high exactly when some flag is set together with its mask bit.
- R11: `req_ok` is high in the same cycle as a request exactly when no rule fires, and it is low when there is no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 4 | Requested target mode code |
| cur_mode | input | 4 | Mode the device is in now |
| xfer_busy | input | 1 | Earlier transition still in progress |
| mode_en | input | 16 | Per-code mode enable vector |
| safe_evt | input | 1 | Safe event pending |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sup | input | 1 | Access is supervisor |
| reg_sel | input | 1 | 0 selects status, 1 selects mask |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Interrupt request |
| req_ok | output | 1 | Request accepted, combinational |

## Verification
`req_ok` and `reg_rdata` are combinational, so the bench samples them one nanosecond after it drives the inputs, before the next rising edge. Flag updates, mask loads and `irq` appear right after the rising edge that follows the stimulus. The bench updates its model at that edge and compares on the next cycle's read, and it checks `irq` right after the edge. Random traffic with a fixed seed is mixed with directed cases: single rules, combined rules, clears racing with sets, and user-mode writes.

// File: rtl/mode_req_monitor.sv
module mode_req_monitor #(
  parameter int MODE_W = 4,
  parameter int NFLAG = 5,
  parameter logic [(1<<MODE_W)-1:0] IMPL_MAP = 16'h00BF,
  parameter logic [(1<<MODE_W)*(1<<MODE_W)-1:0] ALLOW =
    256'hFF7E_FF7E_FF7E_FF7E_FF7E_FF7E_FF7E_FF7E_FF7E_FF7E_FF7E_FF7E_FF7E_FF7F_FFFE_FF7E,
  parameter logic [MODE_W-1:0] RESET_CODE = 4'd0,
  parameter logic [MODE_W-1:0] SAFE_CODE = 4'd2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [MODE_W-1:0]    req_mode,
  input  logic [MODE_W-1:0]    cur_mode,
  input  logic                 xfer_busy,
  input  logic [(1<<MODE_W)-1:0] mode_en,
  input  logic                 safe_evt,
  input  logic                 reg_rd,
  input  logic                 reg_wr,
  input  logic                 reg_sup,
  input  logic                 reg_sel,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 irq,
  output logic                 req_ok
);
  localparam int B_BUSY = 4;
  localparam int B_ILL  = 3;
  localparam int B_DIS  = 2;
  localparam int B_NEX  = 1;
  localparam int B_SAFE = 0;

  logic [NFLAG-1:0] stat, mask, hit, clr;
  logic             exists, wr_ok;

  assign exists = IMPL_MAP[req_mode];
  assign hit[B_BUSY] = req_valid && xfer_busy;
  assign hit[B_ILL]  = req_valid && !ALLOW[{cur_mode, req_mode}];
  assign hit[B_DIS]  = req_valid && exists && !mode_en[req_mode];
  assign hit[B_NEX]  = req_valid && !exists;
  assign hit[B_SAFE] = req_valid && safe_evt && (cur_mode == SAFE_CODE)
                       && (req_mode != SAFE_CODE) && (req_mode != RESET_CODE);

  assign req_ok = req_valid && (hit == '0);
  assign wr_ok  = reg_wr && reg_sup;
  assign clr    = (wr_ok && !reg_sel) ? reg_wdata[NFLAG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      mask <= '0;
    end else begin
      stat <= (stat & ~clr) | hit;
      if (wr_ok && reg_sel) mask <= reg_wdata[NFLAG-1:0];
    end
  end

  assign irq = |(stat & mask);
  assign reg_rdata = !reg_rd ? 32'd0 :
                     {{(32-NFLAG){1'b0}}, reg_sel ? mask : stat};

  assert_busy_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && xfer_busy |=> stat[B_BUSY]);
  assert_nonexist_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !IMPL_MAP[req_mode] |=> stat[B_NEX]);
  assert_user_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !reg_sup && !req_valid |=> $stable(stat) && $stable(mask));
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_sup && !reg_sel && !req_valid
      |=> (stat & $past(reg_wdata[NFLAG-1:0])) == '0);
  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ok |-> req_valid && !xfer_busy && IMPL_MAP[req_mode]);
  assert_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat != '0) && (mask != '0));
  assert_rdata_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:NFLAG] == '0);
endmodule

// File: tb/mode_req_monitor_tb.sv
module mode_req_monitor_tb_top;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, xfer_busy = 0, safe_evt = 0;
  logic [3:0] req_mode = 0, cur_mode = 0;
  logic [15:0] mode_en = 16'hFFFF;
  logic reg_rd = 0, reg_wr = 0, reg_sup = 0, reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, req_ok;
  int checks = 0, errors = 0;
  logic [4:0] m_st = 0, m_mask = 0;

  always #2 clk = ~clk;

  mode_req_monitor dut_i (.clk, .rst_n, .req_valid, .req_mode, .cur_mode,
    .xfer_busy, .mode_en, .safe_evt, .reg_rd, .reg_wr, .reg_sup, .reg_sel,
    .reg_wdata, .reg_rdata, .irq, .req_ok);

  function automatic logic [4:0] rules(logic v, logic [3:0] t, logic [3:0] c,
      logic b, logic [15:0] en, logic sp);
    logic [15:0] impl = 16'h00BF;
    logic allow;
    allow = !(t == 0 && c != 2) && !(t == 7 && c != 1);
    rules = '0;
    if (v) begin
      rules[4] = b;
      rules[3] = !allow;
      rules[2] = impl[t] && !en[t];
      rules[1] = !impl[t];
      rules[0] = sp && c == 2 && t != 0 && t != 2;
    end
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [3:0] t, logic [3:0] c, logic b,
      logic sp, logic rd, logic wr, logic sup, logic sel, logic [31:0] wd);
    req_valid = v; req_mode = t; cur_mode = c; xfer_busy = b; safe_evt = sp;
    reg_rd = rd; reg_wr = wr; reg_sup = sup; reg_sel = sel; reg_wdata = wd;
  endtask

  // checks combinational outputs, advances one edge, updates model, checks irq
  task automatic step(string req);
    logic [4:0] h;
    #1;
    h = rules(req_valid, req_mode, cur_mode, xfer_busy, mode_en, safe_evt);
    chk({req, "/R11 req_ok"}, {31'd0, req_ok}, {31'd0, req_valid && h == 0});
    chk({req, "/R1 rdata"}, reg_rdata,
        reg_rd ? {27'd0, reg_sel ? m_mask : m_st} : 32'd0);
    @(posedge clk);
    if (reg_wr && reg_sup && reg_sel) m_mask = reg_wdata[4:0];
    m_st = (m_st & ~((reg_wr && reg_sup && !reg_sel) ? reg_wdata[4:0] : 5'd0)) | h;
    #1;
    chk({req, "/R10 irq"}, {31'd0, irq}, {31'd0, |(m_st & m_mask)});
    @(negedge clk);
  endtask

  task automatic rd_stat(string req, logic [4:0] exp);
    drive(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    #1 chk(req, reg_rdata, {27'd0, exp});
    @(negedge clk);
  endtask

  task automatic clear_all();
    drive(0, 0, 0, 0, 0, 0, 1, 1, 0, 32'h1F); step("R7 clear");
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rd_stat("R7 reset status", 5'd0);
    drive(0, 0, 0, 0, 0, 1, 0, 0, 1, 0); #1 chk("R10 reset mask", reg_rdata, 0);
    @(negedge clk); rst_n = 1; @(negedge clk);
    // enable all interrupts
    drive(0, 0, 0, 0, 0, 0, 1, 1, 1, 32'hFFFF_FFFF); step("R10 mask load");
    drive(0, 0, 0, 0, 0, 1, 0, 0, 1, 0); #1 chk("R1 mask upper zero", reg_rdata, 32'h1F);
    @(negedge clk);
    // each rule alone
    drive(1, 3, 1, 1, 0, 0, 0, 0, 0, 0); step("R2 busy");
    rd_stat("R2 busy only", 5'b10000); clear_all();
    drive(1, 0, 3, 0, 0, 0, 0, 0, 0, 0); step("R3 illegal");
    rd_stat("R3 illegal only", 5'b01000); clear_all();
    mode_en = 16'hFFF7;
    drive(1, 3, 1, 0, 0, 0, 0, 0, 0, 0); step("R4 disabled");
    rd_stat("R4 disabled only", 5'b00100); clear_all();
    mode_en = 16'h0000;
    drive(1, 6, 1, 0, 0, 0, 0, 0, 0, 0); step("R5 nonexist");
    rd_stat("R5 nonexist not disabled", 5'b00010); clear_all();
    mode_en = 16'hFFFF;
    drive(1, 4, 2, 0, 1, 0, 0, 0, 0, 0); step("R6 safe");
    rd_stat("R6 safe only", 5'b00001); clear_all();
    drive(1, 0, 2, 0, 1, 0, 0, 0, 0, 0); step("R6 reset target exempt");
    drive(1, 2, 2, 0, 1, 0, 0, 0, 0, 0); step("R6 safe target exempt");
    rd_stat("R6 exempt targets", 5'b00000);
    // combined rules
    drive(1, 7, 2, 1, 1, 0, 0, 0, 0, 0); step("R2 R3 R6 combined");
    rd_stat("combined R2 R3 R6", 5'b11001);
    // zero write no effect, partial clear, stays cleared
    drive(0, 0, 0, 0, 0, 0, 1, 1, 0, 32'hFFFF_FFE0); step("R7 zero write");
    rd_stat("R7 zero bits keep", 5'b11001);
    drive(0, 0, 0, 0, 0, 0, 1, 1, 0, 32'h10); step("R7 partial clear");
    rd_stat("R7 bit4 cleared", 5'b01001);
    drive(1, 3, 1, 0, 0, 0, 0, 0, 0, 0); step("R7 accepted request");
    rd_stat("R7 cleared stays cleared", 5'b01001);
    // user writes ignored
    drive(0, 0, 0, 0, 0, 0, 1, 0, 0, 32'h1F); step("R8 user clear");
    rd_stat("R8 status kept", 5'b01001);
    drive(0, 0, 0, 0, 0, 0, 1, 0, 1, 32'h0); step("R8 user mask");
    drive(0, 0, 0, 0, 0, 1, 0, 0, 1, 0); #1 chk("R8 mask kept", reg_rdata, 32'h1F);
    @(negedge clk);
    // set wins over clear
    drive(1, 3, 1, 1, 0, 0, 1, 1, 0, 32'h1F); step("R9 set vs clear");
    rd_stat("R9 set wins", 5'b10000);
    // mask gates irq
    drive(0, 0, 0, 0, 0, 0, 1, 1, 1, 32'h0F); step("R10 mask bit4 off");
    #1 chk("R10 irq masked", {31'd0, irq}, 0); @(negedge clk);
    drive(0, 0, 0, 0, 0, 0, 1, 1, 1, 32'h10); step("R10 mask bit4 on");
    #1 chk("R10 irq unmasked", {31'd0, irq}, 1); @(negedge clk);
    // random traffic
    for (int i = 0; i < 400; i++) begin
      mode_en = 16'($urandom);
      drive(1'($urandom), 4'($urandom), 4'($urandom % 8), ($urandom % 4) == 0,
            1'($urandom), 1'($urandom), ($urandom % 3) == 0, ($urandom % 4) != 0,
            1'($urandom), $urandom);
      step("R2..R11 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule